// File: doc/BRIEF.md
# Cache Request Dispatch with Miss Merging

This block is the request front end of one memory-side cache slice. Two input queues feed it, one carrying reads and one carrying writes. In each cycle it takes at most one request. It checks that request's address against a direct-mapped tag array and then sends it one of three ways: to a response queue (hit), into a small table of outstanding misses (merge), or to a memory-request queue (primary miss). A write that misses allocates no line. It goes to memory with a reduced payload byte count.

A request leaves its input queue only in the cycle in which it is fully handled. Every queue uses a valid/ready handshake, and the ready of an input queue is raised only in the cycle that request is consumed. Both output queues are internal FIFOs. If either one is full at the start of a cycle, dispatch holds. A fill/retire port lets the downstream memory path report that a line has come back. That report frees the matching miss entry and, when requested, installs the line's tag.

Top module: `cache_dispatch_front`

## Requirements
- R1: When the response FIFO or the memory FIFO holds OUT_DEPTH entries at the start of a cycle, neither rd_req_ready nor wr_req_ready is raised that cycle.
- R2: A read that is waiting has priority over a waiting write. wr_req_ready is raised only in a cycle with rd_req_valid low.
- R3: At most one request is consumed per cycle, and a ready is raised only with its own valid.
- R4: A request whose address tag matches the valid tag of its set (set = addr[OFF_W+IDX_W-1:OFF_W], tag = the bits above) is consumed and queued as a reply carrying its id, its address and rsp_is_write = 1 for a write. read_hit_count or write_hit_count rises by one.
- R5: While ideal_mode is 1, every request is treated as a hit, and nothing is sent to the memory FIFO.
- R6: A miss whose line (addr >> OFF_W) matches a valid miss-table entry is consumed without a reply and without a memory request. This holds even when the table is full.
- R7: A write miss is sent to memory with mem_bytes = request bytes − READ_PKT and mem_is_write = 1, and it installs no tag.
- R8: A read miss on a line that is not in the table is sent to memory unchanged (id, address, bytes, mem_is_write = 0) and allocates a table entry. The request appears on mem_valid in the cycle after it is consumed.
- R9: When all MERGE_N table entries are valid, a primary miss is not consumed. It stays at its queue head until an entry is freed.
- R10: A fill_valid pulse frees any table entry for the line of fill_addr. With fill_alloc = 1 it also installs that line's tag, so that later requests to the line hit.
- R11: After reset both output valids are low, both hit counters are zero, and the miss table and tag array are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ideal_mode | input | 1 | Treat every lookup as a hit |
| rd_req_valid | input | 1 | Read queue head is valid |
| rd_req_ready | output | 1 | Read queue head consumed this cycle |
| rd_req_addr | input | ADDR_W | Read byte address |
| rd_req_id | input | ID_W | Read request tag |
| rd_req_bytes | input | BYTES_W | Read payload byte count |
| wr_req_valid | input | 1 | Write queue head is valid |
| wr_req_ready | output | 1 | Write queue head consumed this cycle |
| wr_req_addr | input | ADDR_W | Write byte address |
| wr_req_id | input | ID_W | Write request tag |
| wr_req_bytes | input | BYTES_W | Write payload byte count |
| rsp_valid | output | 1 | Reply available |
| rsp_ready | input | 1 | Reply taken |
| rsp_id | output | ID_W | Reply request tag |
| rsp_addr | output | ADDR_W | Reply address |
| rsp_is_write | output | 1 | Reply belongs to a write |
| mem_valid | output | 1 | Memory request available |
| mem_ready | input | 1 | Memory request taken |
| mem_id | output | ID_W | Memory request tag |
| mem_addr | output | ADDR_W | Memory request address |
| mem_bytes | output | BYTES_W | Memory payload byte count |
| mem_is_write | output | 1 | Memory request is a write |
| fill_valid | input | 1 | A line returned from memory |
| fill_addr | input | ADDR_W | Address of the returned line |
| fill_alloc | input | 1 | Install the returned line's tag |
| read_hit_count | output | CNT_W | Read hits so far |
| write_hit_count | output | CNT_W | Write hits so far |

## Verification
The bench fills the memory FIFO and the response FIFO one at a time. A design that looked at the current-cycle pop rather than the start-of-cycle occupancy would take the next request one cycle early. It also presents a read and a write together, which catches a design that serves the write first or consumes both. It sends a second miss to a line already in flight and fills all eight table entries. A design without merging would send a duplicate memory request, and one that ignored the full table would drop or overwrite an entry. A same-line merge must still go through while the table is full. Finally, the bench retires a write-miss entry without installing a tag and checks that the next read to that line misses. It also checks the reduced byte count, which a design that allocated on a write or reused the read size would get wrong.

// File: rtl/cdf_pkg.sv
package cdf_pkg;

   // which input queue the arbiter selected this cycle
   typedef enum logic [1:0] {
      PICK_NONE = 2'd0,
      PICK_RD   = 2'd1,
      PICK_WR   = 2'd2
   } pick_e;

   // disposition of the selected request
   typedef enum logic [1:0] {
      ACT_STALL = 2'd0,
      ACT_HIT   = 2'd1,
      ACT_MERGE = 2'd2,
      ACT_FWD   = 2'd3
   } act_e;

endpackage

// File: rtl/cdf_fifo.sv
module cdf_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   output logic             full,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [WIDTH-1:0] out_data
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 1) begin : g_bad_depth
      $error("cdf_fifo: DEPTH must be at least 1");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("cdf_fifo: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] store [DEPTH];
   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] rd_ptr;
   logic [CNT_W-1:0] count;
   logic             do_push;
   logic             do_pop;

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign full      = (count == CNT_W'(DEPTH));
   assign out_valid = (count != '0);
   assign out_data  = store[rd_ptr];
   assign do_push   = push && !full;
   assign do_pop    = out_valid && out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= bump(wr_ptr);
         if (do_pop)  rd_ptr <= bump(rd_ptr);
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) store[wr_ptr] <= push_data;
   end

endmodule

// File: rtl/cdf_tag_array.sv
module cdf_tag_array #(
   parameter int ADDR_W = 16,
   parameter int OFF_W  = 5,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] look_addr,
   output logic              look_hit,
   input  logic              fill_en,
   input  logic [ADDR_W-1:0] fill_addr
);
   localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
   localparam int SETS  = 1 << IDX_W;

   if (TAG_W < 1) begin : g_bad_tag
      $error("cdf_tag_array: no tag bits remain");
   end

   logic [TAG_W-1:0] look_tag;
   logic [TAG_W-1:0] fill_tag;

   assign look_tag = look_addr[ADDR_W-1 -: TAG_W];
   assign fill_tag = fill_addr[ADDR_W-1 -: TAG_W];

   if (IDX_W == 0) begin : g_single
      // one-line variant: a lone tag register
      logic [TAG_W-1:0] tag_q;
      logic             vld_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tag_q <= '0;
            vld_q <= 1'b0;
         end else if (fill_en) begin
            tag_q <= fill_tag;
            vld_q <= 1'b1;
         end
      end
      assign look_hit = vld_q && (tag_q == look_tag);
   end else begin : g_sets
      logic [TAG_W-1:0] tags [SETS];
      logic [SETS-1:0]  vld;
      logic [IDX_W-1:0] look_idx;
      logic [IDX_W-1:0] fill_idx;

      assign look_idx = look_addr[OFF_W +: IDX_W];
      assign fill_idx = fill_addr[OFF_W +: IDX_W];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld <= '0;
            for (int s = 0; s < SETS; s++) tags[s] <= '0;
         end else if (fill_en) begin
            vld[fill_idx]  <= 1'b1;
            tags[fill_idx] <= fill_tag;
         end
      end
      assign look_hit = vld[look_idx] && (tags[look_idx] == look_tag);
   end

endmodule

// File: rtl/cdf_merge_table.sv
module cdf_merge_table #(
   parameter int LINE_W  = 11,
   parameter int ENTRIES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINE_W-1:0] probe_line,
   output logic              probe_hit,
   output logic              tbl_full,
   input  logic              alloc_en,
   input  logic              retire_en,
   input  logic [LINE_W-1:0] retire_line
);
   if (ENTRIES < 1) begin : g_bad_entries
      $error("cdf_merge_table: ENTRIES must be at least 1");
   end

   logic [LINE_W-1:0]  line_q [ENTRIES];
   logic [ENTRIES-1:0] vld_q;
   logic [ENTRIES-1:0] probe_match;
   logic [ENTRIES-1:0] retire_match;
   logic [ENTRIES-1:0] alloc_sel;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign probe_match[e]  = vld_q[e] && (line_q[e] == probe_line);
      assign retire_match[e] = vld_q[e] && (line_q[e] == retire_line);
   end

   assign probe_hit = |probe_match;
   assign tbl_full  = &vld_q;

   // lowest free slot, one-hot
   always_comb begin
      alloc_sel = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (!vld_q[e]) alloc_sel = ENTRIES'(1) << e;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         for (int e = 0; e < ENTRIES; e++) line_q[e] <= '0;
      end else begin
         for (int e = 0; e < ENTRIES; e++) begin
            if (alloc_en && alloc_sel[e]) begin
               vld_q[e]  <= 1'b1;
               line_q[e] <= probe_line;
            end else if (retire_en && retire_match[e]) begin
               vld_q[e] <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/cdf_arbiter.sv
module cdf_arbiter
   import cdf_pkg::*;
(
   input  logic  go,
   input  logic  rd_valid,
   input  logic  wr_valid,
   output pick_e pick
);
   always_comb begin
      if (!go)           pick = PICK_NONE;
      else if (rd_valid) pick = PICK_RD;
      else if (wr_valid) pick = PICK_WR;
      else               pick = PICK_NONE;
   end
endmodule

// File: rtl/cache_dispatch_front.sv
module cache_dispatch_front
   import cdf_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int ID_W      = 4,
   parameter int BYTES_W   = 8,
   parameter int OFF_W     = 5,
   parameter int IDX_W     = 3,
   parameter int MERGE_N   = 8,
   parameter int OUT_DEPTH = 2,
   parameter int READ_PKT  = 8,
   parameter int CNT_W     = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ideal_mode,
   input  logic               rd_req_valid,
   output logic               rd_req_ready,
   input  logic [ADDR_W-1:0]  rd_req_addr,
   input  logic [ID_W-1:0]    rd_req_id,
   input  logic [BYTES_W-1:0] rd_req_bytes,
   input  logic               wr_req_valid,
   output logic               wr_req_ready,
   input  logic [ADDR_W-1:0]  wr_req_addr,
   input  logic [ID_W-1:0]    wr_req_id,
   input  logic [BYTES_W-1:0] wr_req_bytes,
   output logic               rsp_valid,
   input  logic               rsp_ready,
   output logic [ID_W-1:0]    rsp_id,
   output logic [ADDR_W-1:0]  rsp_addr,
   output logic               rsp_is_write,
   output logic               mem_valid,
   input  logic               mem_ready,
   output logic [ID_W-1:0]    mem_id,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [BYTES_W-1:0] mem_bytes,
   output logic               mem_is_write,
   input  logic               fill_valid,
   input  logic [ADDR_W-1:0]  fill_addr,
   input  logic               fill_alloc,
   output logic [CNT_W-1:0]   read_hit_count,
   output logic [CNT_W-1:0]   write_hit_count
);
   localparam int LINE_W = ADDR_W - OFF_W;
   localparam int RSP_W  = ID_W + ADDR_W + 1;
   localparam int MEM_W  = ID_W + ADDR_W + BYTES_W + 1;

   if (OFF_W < 2) begin : g_bad_off
      $error("cache_dispatch_front: a line must hold a 4-byte access");
   end
   if (READ_PKT >= (1 << BYTES_W)) begin : g_bad_pkt
      $error("cache_dispatch_front: READ_PKT does not fit BYTES_W");
   end
   if (ADDR_W <= OFF_W + IDX_W) begin : g_bad_addr
      $error("cache_dispatch_front: address too narrow for geometry");
   end

   // output queue state
   logic rsp_full;
   logic mem_full;
   logic rsp_push;
   logic mem_push;

   // selected request
   pick_e              pick;
   act_e               act;
   logic               go;
   logic [ADDR_W-1:0]  cur_addr;
   logic [ID_W-1:0]    cur_id;
   logic [BYTES_W-1:0] cur_bytes;
   logic               cur_wr;
   logic [LINE_W-1:0]  cur_line;
   logic [BYTES_W-1:0] fwd_bytes;

   // lookup results
   logic tag_hit;
   logic merge_hit;
   logic tbl_full;
   logic is_hit;

   assign go = !rsp_full && !mem_full;

   cdf_arbiter u_arb (
      .go       (go),
      .rd_valid (rd_req_valid),
      .wr_valid (wr_req_valid),
      .pick     (pick)
   );

   always_comb begin
      if (pick == PICK_WR) begin
         cur_addr  = wr_req_addr;
         cur_id    = wr_req_id;
         cur_bytes = wr_req_bytes;
         cur_wr    = 1'b1;
      end else begin
         cur_addr  = rd_req_addr;
         cur_id    = rd_req_id;
         cur_bytes = rd_req_bytes;
         cur_wr    = 1'b0;
      end
   end

   assign cur_line = cur_addr[ADDR_W-1:OFF_W];

   cdf_tag_array #(
      .ADDR_W (ADDR_W),
      .OFF_W  (OFF_W),
      .IDX_W  (IDX_W)
   ) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .look_addr (cur_addr),
      .look_hit  (tag_hit),
      .fill_en   (fill_valid && fill_alloc),
      .fill_addr (fill_addr)
   );

   cdf_merge_table #(
      .LINE_W  (LINE_W),
      .ENTRIES (MERGE_N)
   ) u_merge (
      .clk         (clk),
      .rst_n       (rst_n),
      .probe_line  (cur_line),
      .probe_hit   (merge_hit),
      .tbl_full    (tbl_full),
      .alloc_en    (mem_push),
      .retire_en   (fill_valid),
      .retire_line (fill_addr[ADDR_W-1:OFF_W])
   );

   assign is_hit = ideal_mode || tag_hit;

   always_comb begin
      if (pick == PICK_NONE) act = ACT_STALL;
      else if (is_hit)       act = ACT_HIT;
      else if (merge_hit)    act = ACT_MERGE;
      else if (tbl_full)     act = ACT_STALL;
      else                   act = ACT_FWD;
   end

   assign rd_req_ready = (act != ACT_STALL) && (pick == PICK_RD);
   assign wr_req_ready = (act != ACT_STALL) && (pick == PICK_WR);
   assign rsp_push     = (act == ACT_HIT);
   assign mem_push     = (act == ACT_FWD);

   // no-write-allocate: a write miss carries data only
   assign fwd_bytes = cur_wr ? (cur_bytes - BYTES_W'(READ_PKT)) : cur_bytes;

   logic [RSP_W-1:0] rsp_in;
   logic [RSP_W-1:0] rsp_out;
   logic [MEM_W-1:0] mem_in;
   logic [MEM_W-1:0] mem_out;

   assign rsp_in = {cur_id, cur_addr, cur_wr};
   assign mem_in = {cur_id, cur_addr, fwd_bytes, cur_wr};

   cdf_fifo #(
      .WIDTH (RSP_W),
      .DEPTH (OUT_DEPTH)
   ) u_rsp_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (rsp_push),
      .push_data (rsp_in),
      .full      (rsp_full),
      .out_valid (rsp_valid),
      .out_ready (rsp_ready),
      .out_data  (rsp_out)
   );

   cdf_fifo #(
      .WIDTH (MEM_W),
      .DEPTH (OUT_DEPTH)
   ) u_mem_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (mem_push),
      .push_data (mem_in),
      .full      (mem_full),
      .out_valid (mem_valid),
      .out_ready (mem_ready),
      .out_data  (mem_out)
   );

   assign {rsp_id, rsp_addr, rsp_is_write}           = rsp_out;
   assign {mem_id, mem_addr, mem_bytes, mem_is_write} = mem_out;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         read_hit_count  <= '0;
         write_hit_count <= '0;
      end else if (rsp_push) begin
         if (cur_wr) write_hit_count <= write_hit_count + 1'b1;
         else        read_hit_count  <= read_hit_count + 1'b1;
      end
   end

endmodule

// File: rtl/cdf_checker.sv
module cdf_checker (
   input logic clk,
   input logic rst_n,
   input logic ideal_mode,
   input logic rd_req_valid,
   input logic rd_req_ready,
   input logic wr_req_valid,
   input logic wr_req_ready,
   input logic rsp_full,
   input logic mem_full,
   input logic mem_push,
   input logic tbl_full,
   input logic rsp_valid,
   input logic mem_valid
);
   assert_stall_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_full || mem_full) |-> !(rd_req_ready || wr_req_ready));

   assert_read_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req_ready |-> !rd_req_valid);

   assert_single_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req_ready && wr_req_ready));

   assert_ready_has_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_ready |-> rd_req_valid) and (wr_req_ready |-> wr_req_valid));

   assert_ideal_no_mem_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ideal_mode |-> !mem_push);

   assert_fwd_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_push |=> mem_valid);

   assert_table_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_push |-> !tbl_full);

   assert_reset_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!rsp_valid && !mem_valid));
endmodule

bind cache_dispatch_front cdf_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ideal_mode   (ideal_mode),
   .rd_req_valid (rd_req_valid),
   .rd_req_ready (rd_req_ready),
   .wr_req_valid (wr_req_valid),
   .wr_req_ready (wr_req_ready),
   .rsp_full     (rsp_full),
   .mem_full     (mem_full),
   .mem_push     (mem_push),
   .tbl_full     (tbl_full),
   .rsp_valid    (rsp_valid),
   .mem_valid    (mem_valid)
);

// File: tb/cache_dispatch_front_test.sv
module cache_dispatch_front_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ideal_mode = 1'b0;
   logic        rd_req_valid = 1'b0;
   logic        rd_req_ready;
   logic [15:0] rd_req_addr = '0;
   logic [3:0]  rd_req_id = '0;
   logic [7:0]  rd_req_bytes = '0;
   logic        wr_req_valid = 1'b0;
   logic        wr_req_ready;
   logic [15:0] wr_req_addr = '0;
   logic [3:0]  wr_req_id = '0;
   logic [7:0]  wr_req_bytes = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic [3:0]  rsp_id;
   logic [15:0] rsp_addr;
   logic        rsp_is_write;
   logic        mem_valid;
   logic        mem_ready = 1'b0;
   logic [3:0]  mem_id;
   logic [15:0] mem_addr;
   logic [7:0]  mem_bytes;
   logic        mem_is_write;
   logic        fill_valid = 1'b0;
   logic [15:0] fill_addr = '0;
   logic        fill_alloc = 1'b0;
   logic [15:0] read_hit_count;
   logic [15:0] write_hit_count;

   int checks = 0;
   int errors = 0;
   localparam int READ_PKT = 8;

   always #5 clk = ~clk;

   cache_dispatch_front uut (
      .clk(clk), .rst_n(rst_n), .ideal_mode(ideal_mode),
      .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
      .rd_req_addr(rd_req_addr), .rd_req_id(rd_req_id), .rd_req_bytes(rd_req_bytes),
      .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready),
      .wr_req_addr(wr_req_addr), .wr_req_id(wr_req_id), .wr_req_bytes(wr_req_bytes),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_id(rsp_id),
      .rsp_addr(rsp_addr), .rsp_is_write(rsp_is_write),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_id(mem_id),
      .mem_addr(mem_addr), .mem_bytes(mem_bytes), .mem_is_write(mem_is_write),
      .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_alloc(fill_alloc),
      .read_hit_count(read_hit_count), .write_hit_count(write_hit_count)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_rd(input logic v, input logic [15:0] a, input logic [3:0] id, input logic [7:0] b);
      rd_req_valid = v; rd_req_addr = a; rd_req_id = id; rd_req_bytes = b;
   endtask

   task automatic set_wr(input logic v, input logic [15:0] a, input logic [3:0] id, input logic [7:0] b);
      wr_req_valid = v; wr_req_addr = a; wr_req_id = id; wr_req_bytes = b;
   endtask

   // present one read at a negedge, check it is consumed, advance one cycle
   task automatic send_rd(input string req, input logic [15:0] a, input logic [3:0] id, input logic [7:0] b);
      set_rd(1'b1, a, id, b);
      #1 check({req, " read consumed"}, 32'(rd_req_ready), 32'd1);
      cyc();
      rd_req_valid = 1'b0;
      #1;
   endtask

   task automatic send_wr(input string req, input logic [15:0] a, input logic [3:0] id, input logic [7:0] b);
      set_wr(1'b1, a, id, b);
      #1 check({req, " write consumed"}, 32'(wr_req_ready), 32'd1);
      cyc();
      wr_req_valid = 1'b0;
      #1;
   endtask

   task automatic pop_mem(input string req, input logic [3:0] id, input logic [15:0] a, input logic w, input logic [7:0] b);
      check({req, " mem_valid"}, 32'(mem_valid), 32'd1);
      check({req, " mem fields"}, {mem_id, mem_addr, mem_is_write, mem_bytes[6:0]},
            {id, a, w, b[6:0]});
      check({req, " mem bytes"}, 32'(mem_bytes), 32'(b));
      mem_ready = 1'b1;
      cyc();
      mem_ready = 1'b0;
      #1;
   endtask

   task automatic pop_rsp(input string req, input logic [3:0] id, input logic [15:0] a, input logic w);
      check({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
      check({req, " rsp fields"}, {11'd0, rsp_id, rsp_addr, rsp_is_write}, {11'd0, id, a, w});
      rsp_ready = 1'b1;
      cyc();
      rsp_ready = 1'b0;
      #1;
   endtask

   task automatic fill(input logic [15:0] a, input logic alloc);
      fill_valid = 1'b1; fill_addr = a; fill_alloc = alloc;
      cyc();
      fill_valid = 1'b0; fill_alloc = 1'b0;
      #1;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) cyc();
      rst_n = 1'b1;
      #1;
      // R11: idle after reset
      check("R11 rsp_valid", 32'(rsp_valid), 32'd0);
      check("R11 mem_valid", 32'(mem_valid), 32'd0);
      check("R11 read_hit_count", 32'(read_hit_count), 32'd0);
      check("R11 write_hit_count", 32'(write_hit_count), 32'd0);
      check("R11 no ready", 32'({rd_req_ready, wr_req_ready}), 32'd0);

      // R8: primary read miss goes to memory unchanged
      send_rd("R8", 16'h0120, 4'd1, 8'd32);
      check("R8 no reply", 32'(rsp_valid), 32'd0);
      pop_mem("R8", 4'd1, 16'h0120, 1'b0, 8'd32);

      // R6: second miss on the same line merges
      send_rd("R6", 16'h0124, 4'd2, 8'd32);
      check("R6 no mem request", 32'(mem_valid), 32'd0);
      check("R6 no reply", 32'(rsp_valid), 32'd0);

      // R7: write miss, bytes reduced by READ_PKT
      send_wr("R7", 16'h0300, 4'd3, 8'd40);
      pop_mem("R7", 4'd3, 16'h0300, 1'b1, 8'(40 - READ_PKT));

      // R10 + R4: fill installs line 0x0120, later accesses hit
      fill(16'h0120, 1'b1);
      send_rd("R4", 16'h013C, 4'd4, 8'd32);
      check("R4 no mem on hit", 32'(mem_valid), 32'd0);
      pop_rsp("R4 read hit", 4'd4, 16'h013C, 1'b0);
      check("R4 read_hit_count", 32'(read_hit_count), 32'd1);
      send_wr("R4", 16'h0128, 4'd5, 8'd16);
      pop_rsp("R4 write hit", 4'd5, 16'h0128, 1'b1);
      check("R4 write_hit_count", 32'(write_hit_count), 32'd1);

      // R10 + R7: retire write-miss line without tag; read misses as primary
      fill(16'h0300, 1'b0);
      send_rd("R10", 16'h0310, 4'd6, 8'd32);
      check("R7 write did not allocate, read hit count", 32'(read_hit_count), 32'd1);
      pop_mem("R10 retired line refetched", 4'd6, 16'h0310, 1'b0, 8'd32);

      // R2 + R3: read beats write
      set_rd(1'b1, 16'h0520, 4'd7, 8'd32);
      set_wr(1'b1, 16'h0720, 4'd8, 8'd24);
      #1 check("R2 read ready", 32'(rd_req_ready), 32'd1);
      check("R3 write held", 32'(wr_req_ready), 32'd0);
      cyc();
      rd_req_valid = 1'b0;
      #1 check("R2 write ready once read gone", 32'(wr_req_ready), 32'd1);
      cyc();
      wr_req_valid = 1'b0;
      #1;
      pop_mem("R2 read first", 4'd7, 16'h0520, 1'b0, 8'd32);
      pop_mem("R2 write second", 4'd8, 16'h0720, 1'b1, 8'(24 - READ_PKT));

      // R1: memory FIFO full stalls dispatch
      send_rd("R1", 16'h0920, 4'd9, 8'd32);
      send_rd("R1", 16'h0B20, 4'd10, 8'd32);
      set_rd(1'b1, 16'h0D20, 4'd11, 8'd32);
      #1 check("R1 stall mem full", 32'(rd_req_ready), 32'd0);
      cyc();
      #1 check("R1 still stalled", 32'(rd_req_ready), 32'd0);
      check("R1 head id", 32'(mem_id), 32'd9);
      mem_ready = 1'b1;
      #1 check("R1 stall during pop cycle", 32'(rd_req_ready), 32'd0);
      cyc();
      mem_ready = 1'b0;
      #1 check("R1 resumes", 32'(rd_req_ready), 32'd1);
      cyc();
      rd_req_valid = 1'b0;
      #1;
      pop_mem("R1 order", 4'd10, 16'h0B20, 1'b0, 8'd32);
      pop_mem("R1 order", 4'd11, 16'h0D20, 1'b0, 8'd32);

      // R5 + R1: ideal mode hits, response FIFO fills
      ideal_mode = 1'b1;
      send_rd("R5", 16'h0F20, 4'd12, 8'd32);
      send_rd("R5", 16'h0F40, 4'd13, 8'd32);
      set_rd(1'b1, 16'h0F60, 4'd14, 8'd32);
      #1 check("R1 stall rsp full", 32'(rd_req_ready), 32'd0);
      check("R5 no mem request", 32'(mem_valid), 32'd0);
      check("R5 read_hit_count", 32'(read_hit_count), 32'd3);
      rd_req_valid = 1'b0;
      ideal_mode = 1'b0;
      #1;
      pop_rsp("R5", 4'd12, 16'h0F20, 1'b0);
      pop_rsp("R5", 4'd13, 16'h0F40, 1'b0);

      // R9: fill the table to 8 entries
      send_rd("R9", 16'h1120, 4'd15, 8'd32);
      pop_mem("R9", 4'd15, 16'h1120, 1'b0, 8'd32);
      send_rd("R9", 16'h1320, 4'd0, 8'd32);
      pop_mem("R9", 4'd0, 16'h1320, 1'b0, 8'd32);
      set_rd(1'b1, 16'h1520, 4'd1, 8'd32);
      #1 check("R9 table full stall", 32'(rd_req_ready), 32'd0);
      cyc();
      #1 check("R9 still held", 32'(rd_req_ready), 32'd0);
      check("R9 no mem request", 32'(mem_valid), 32'd0);
      rd_req_valid = 1'b0;
      #1;
      // R6: merge still allowed with full table
      send_rd("R6 full table", 16'h0530, 4'd2, 8'd32);
      check("R6 full table no mem", 32'(mem_valid), 32'd0);
      // R10: retiring frees a slot
      fill(16'h0920, 1'b0);
      send_rd("R10 slot freed", 16'h1520, 4'd1, 8'd32);
      pop_mem("R10 slot freed", 4'd1, 16'h1520, 1'b0, 8'd32);

      repeat (2) cyc();
      finish_run();
   end
endmodule